// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block is the master-side controller that performs one write command to a two-wire serial memory and then finds out when the memory has finished its internal write cycle. It does not wait a fixed worst-case delay. It probes the device repeatedly and treats the first acknowledged control byte as proof that the write cycle is over. The block works above a byte-level bus engine. Each command to that engine is a one-cycle strobe with an opcode. The engine replies with a one-cycle done pulse and the ack bit it sampled on the bus.

A request carries the 7-bit device address, a byte count and a packed payload. The block sends the write command and ends it with a stop, which is what starts the memory's write cycle. It then begins probing at once. Each probe is a start followed by the control byte with the read/write bit cleared. A probe that is not acknowledged is closed with a stop and tried again, up to a programmable limit. When a probe is acknowledged, a configuration input decides the next step. The block either keeps the bus for the next operation or releases it with a stop. When the limit is used up, the block reports a timeout and returns to idle.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset the block is idle: busy, done, timeout and cmd_valid are all 0.
- R2: A request taken while idle produces the strobes START (opcode 0), WRITE_BYTE (opcode 2) with data {dev_addr, 1'b0}, one WRITE_BYTE per payload byte, and then STOP (opcode 1). Payload byte i is payload[8i+7:8i], and byte 0 goes first. A byte_cnt of 0 sends no payload bytes. A byte_cnt above MAX_BYTES is treated as MAX_BYTES.
- R3: The first probe START is strobed in the cycle right after the engine's done pulse for the write-command STOP. No idle cycles are inserted.
- R4: Each probe is a START strobe followed by a WRITE_BYTE strobe with data {dev_addr, 1'b0}.
- R5: When the ack bit of a probe's control byte is 1 (not acknowledged), the next strobe is STOP, and after that comes a new probe START.
- R6: When the ack bit of a probe's control byte is 0 (acknowledged) and keep_bus was 1 at request time, done pulses for one cycle and no further strobe follows. With keep_bus 0, one STOP is strobed first and done pulses after its engine done.
- R7: If poll_limit probes in a row are not acknowledged, and each is closed by its STOP, timeout pulses for one cycle and no further strobe follows. A poll_limit of 0 behaves as 1.
- R8: Each strobe is one cycle long, and no new strobe is issued before the engine has returned done for the previous one.
- R9: A go pulse while busy is ignored. The command in progress keeps its latched address and payload.
- R10: The ack bit returned during the write command has no effect on the strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request pulse, taken only while idle |
| dev_addr | input | 7 | Device address of the memory |
| byte_cnt | input | CNT_W (4) | Number of payload bytes |
| payload | input | MAX_BYTES*8 (64) | Payload bytes; byte 0 in the low bits |
| poll_limit | input | POLL_W (8) | Maximum number of probes |
| keep_bus | input | 1 | 1 = hold the bus after a successful probe |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: write cycle confirmed complete |
| timeout | output | 1 | One-cycle pulse: probe limit exhausted |
| cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| cmd_op | output | 2 | Opcode: 0 START, 1 STOP, 2 WRITE_BYTE |
| cmd_data | output | 8 | Byte to send for WRITE_BYTE |
| eng_done | input | 1 | Engine finished the last command |
| eng_ack_bit | input | 1 | Sampled ack bit, 0 = acknowledged |

## Verification
The hardest situation to reach is the boundary at the probe limit. The device has to refuse exactly poll_limit-1 probes and then accept one, and in a separate case refuse all poll_limit of them, so that the difference between success and timeout comes down to one counter comparison. The bench's engine model counts probes inside each command and refuses the first K of them. Directed cases place K at limit-1, at limit, and at limit 0, and random cases with random engine latencies cover the rest. Random ack bits during the write phase and go pulses injected while busy show that neither one changes the recorded strobe sequence.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
   typedef enum logic [1:0] {
      OP_START   = 2'd0,
      OP_STOP    = 2'd1,
      OP_WRBYTE  = 2'd2
   } op_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WSTART,
      ST_WCTRL,
      ST_WDATA,
      ST_WSTOP,
      ST_PSTART,
      ST_PCTRL,
      ST_PSTOP,
      ST_FSTOP
   } state_t;
endpackage

// File: rtl/ackpoll_byte_sel.sv
module ackpoll_byte_sel #(
   parameter int MAX_BYTES = 8,
   parameter int IDX_W     = 4
) (
   input  logic [MAX_BYTES*8-1:0] payload,
   input  logic [IDX_W-1:0]       idx,
   output logic [7:0]             byte_out
);
   generate
      if (MAX_BYTES == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^idx;
         assign byte_out   = payload[7:0];
      end else begin : g_multi
         always_comb begin
            byte_out = 8'h00;
            for (int i = 0; i < MAX_BYTES; i++) begin
               if (idx == IDX_W'(i)) byte_out = payload[i*8 +: 8];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ackpoll_poll_ctr.sv
module ackpoll_poll_ctr #(
   parameter int POLL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [POLL_W-1:0] limit,
   output logic              reached
);
   localparam logic [POLL_W-1:0] CNT_MAX = {POLL_W{1'b1}};

   logic [POLL_W-1:0] cnt;
   logic [POLL_W-1:0] eff_limit;

   assign eff_limit = (limit == '0) ? POLL_W'(1) : limit;
   assign reached   = (cnt >= eff_limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
   import ackpoll_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int MAX_BYTES = 8,
   parameter int POLL_W    = 8,
   localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [ADDR_W-1:0]      dev_addr,
   input  logic [CNT_W-1:0]       byte_cnt,
   input  logic [MAX_BYTES*8-1:0] payload,
   input  logic [POLL_W-1:0]      poll_limit,
   input  logic                   keep_bus,
   output logic                   busy,
   output logic                   done,
   output logic                   timeout,
   output logic                   cmd_valid,
   output logic [1:0]             cmd_op,
   output logic [7:0]             cmd_data,
   input  logic                   eng_done,
   input  logic                   eng_ack_bit
);
   generate
      if (ADDR_W != 7) begin : g_bad_addr
         $error("ackpoll_seq: ADDR_W must be 7");
      end
      if (MAX_BYTES < 1) begin : g_bad_bytes
         $error("ackpoll_seq: MAX_BYTES must be at least 1");
      end
      if (POLL_W < 1) begin : g_bad_poll
         $error("ackpoll_seq: POLL_W must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_BYTES);

   state_t                 state;
   logic                   issued;
   logic [CNT_W-1:0]       idx;
   logic [CNT_W-1:0]       n_lat;
   logic [ADDR_W-1:0]      addr_lat;
   logic [MAX_BYTES*8-1:0] pay_lat;
   logic [POLL_W-1:0]      limit_lat;
   logic                   keep_lat;
   logic [7:0]             data_byte;
   logic                   limit_hit;
   logic                   step;

   assign busy      = (state != ST_IDLE);
   assign cmd_valid = busy && !issued;
   assign step      = busy && issued && eng_done;

   ackpoll_byte_sel #(.MAX_BYTES(MAX_BYTES), .IDX_W(CNT_W)) u_sel (
      .payload  (pay_lat),
      .idx      (idx),
      .byte_out (data_byte)
   );

   ackpoll_poll_ctr #(.POLL_W(POLL_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state == ST_WSTOP),
      .inc     (step && state == ST_PCTRL),
      .limit   (limit_lat),
      .reached (limit_hit)
   );

   always_comb begin
      cmd_op   = OP_START;
      cmd_data = 8'h00;
      unique case (state)
         ST_WCTRL, ST_PCTRL: begin
            cmd_op   = OP_WRBYTE;
            cmd_data = {addr_lat, 1'b0};
         end
         ST_WDATA: begin
            cmd_op   = OP_WRBYTE;
            cmd_data = data_byte;
         end
         ST_WSTOP, ST_PSTOP, ST_FSTOP: cmd_op = OP_STOP;
         default: cmd_op = OP_START;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         issued    <= 1'b0;
         idx       <= '0;
         n_lat     <= '0;
         addr_lat  <= '0;
         pay_lat   <= '0;
         limit_lat <= '0;
         keep_lat  <= 1'b0;
         done      <= 1'b0;
         timeout   <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         if (state == ST_IDLE) begin
            if (go) begin
               addr_lat  <= dev_addr;
               pay_lat   <= payload;
               n_lat     <= (byte_cnt > CNT_CAP) ? CNT_CAP : byte_cnt;
               limit_lat <= poll_limit;
               keep_lat  <= keep_bus;
               issued    <= 1'b0;
               state     <= ST_WSTART;
            end
         end else if (!issued) begin
            issued <= 1'b1;
         end else if (eng_done) begin
            issued <= 1'b0;
            unique case (state)
               ST_WSTART: state <= ST_WCTRL;
               ST_WCTRL: begin
                  idx   <= '0;
                  state <= (n_lat == '0) ? ST_WSTOP : ST_WDATA;
               end
               ST_WDATA: begin
                  if (idx == n_lat - 1'b1) state <= ST_WSTOP;
                  else                     idx   <= idx + 1'b1;
               end
               ST_WSTOP:  state <= ST_PSTART;
               ST_PSTART: state <= ST_PCTRL;
               ST_PCTRL: begin
                  if (eng_ack_bit)   state <= ST_PSTOP;
                  else if (keep_lat) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else           state <= ST_FSTOP;
               end
               ST_PSTOP: begin
                  if (limit_hit) begin
                     state   <= ST_IDLE;
                     timeout <= 1'b1;
                  end else state <= ST_PSTART;
               end
               ST_FSTOP: begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       busy,
   input logic       done,
   input logic       timeout,
   input logic       cmd_valid,
   input logic [1:0] cmd_op,
   input logic       eng_done
);
   // R2: a command always opens with a START strobe
   p_open_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cmd_valid && cmd_op == 2'd0));

   // R8: strobes last one cycle
   p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R8: completion only follows an engine reply
   p_end_on_engine_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> $past(eng_done));

   // R7: success and timeout never coincide
   p_excl_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   // R6: nothing is strobed after completion unless a new request arrives
   p_quiet_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((done || timeout) && !go) |=> !cmd_valid);
endmodule

bind ackpoll_seq ackpoll_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .busy      (busy),
   .done      (done),
   .timeout   (timeout),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .eng_done  (eng_done)
);

// File: tb/ackpoll_seq_bench.sv
`timescale 1ns/1ps
module ackpoll_seq_bench;
   localparam int MAXB  = 8;
   localparam int CW    = 4;
   localparam int PW    = 8;
   localparam int LOGN  = 256;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            go = 1'b0;
   logic [6:0]      dev_addr = '0;
   logic [CW-1:0]   byte_cnt = '0;
   logic [MAXB*8-1:0] payload = '0;
   logic [PW-1:0]   poll_limit = '0;
   logic            keep_bus = 1'b0;
   logic            busy, done, timeout, cmd_valid;
   logic [1:0]      cmd_op;
   logic [7:0]      cmd_data;
   logic            eng_done = 1'b0;
   logic            eng_ack_bit = 1'b1;

   always #4 clk = ~clk;

   ackpoll_seq u_ackpoll_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
      .byte_cnt(byte_cnt), .payload(payload), .poll_limit(poll_limit),
      .keep_bus(keep_bus), .busy(busy), .done(done), .timeout(timeout),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .eng_done(eng_done), .eng_ack_bit(eng_ack_bit)
   );

   int errors = 0;
   int checks = 0;

   // engine model state
   int         cyc = 0;
   logic [1:0] log_op [LOGN];
   logic [7:0] log_dat [LOGN];
   int         log_len = 0;
   int         stop_cnt = 0;
   int         poll_i = 0;
   int         busy_polls = 0;
   bit         pend = 0;
   bit         pend_ack = 1;
   bit         pend_first_stop = 0;
   int         dly = 0;
   int         stop_done_cyc = -1;
   int         first_poll_cyc = -1;
   bit         overlap_seen = 0;

   // expected sequence
   logic [1:0] exp_op [LOGN];
   logic [7:0] exp_dat [LOGN];
   int         exp_len;
   int         exp_wlen;
   bit         exp_tmo;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   initial begin : engine
      forever begin
         @(negedge clk);
         cyc++;
         eng_done = 1'b0;
         if (pend) begin
            if (dly == 0) begin
               eng_done    = 1'b1;
               eng_ack_bit = pend_ack;
               pend        = 0;
               if (pend_first_stop) stop_done_cyc = cyc;
            end else dly--;
         end
         if (cmd_valid) begin
            if (pend || eng_done) overlap_seen = 1;
            if (log_len < LOGN) begin
               log_op[log_len]  = cmd_op;
               log_dat[log_len] = cmd_data;
            end
            log_len++;
            pend_first_stop = 0;
            pend_ack = 1'($urandom_range(0, 1));
            if (cmd_op == 2'd1) begin
               pend_first_stop = (stop_cnt == 0);
               stop_cnt++;
            end else if (cmd_op == 2'd0) begin
               if (stop_cnt == 1 && first_poll_cyc < 0) first_poll_cyc = cyc;
            end else if (stop_cnt >= 1) begin
               pend_ack = (poll_i < busy_polls);
               poll_i++;
            end
            pend = 1;
            dly  = $urandom_range(0, 3);
         end
      end
   end

   task automatic build_expect(input logic [6:0] a, input int n, input logic [MAXB*8-1:0] p,
                               input int k, input int lim, input bit keep);
      int nn = (n > MAXB) ? MAXB : n;
      int el = (lim == 0) ? 1 : lim;
      exp_len = 0;
      exp_op[exp_len] = 2'd0; exp_dat[exp_len] = 8'h00; exp_len++;
      exp_op[exp_len] = 2'd2; exp_dat[exp_len] = {a, 1'b0}; exp_len++;
      for (int i = 0; i < nn; i++) begin
         exp_op[exp_len] = 2'd2; exp_dat[exp_len] = p[i*8 +: 8]; exp_len++;
      end
      exp_op[exp_len] = 2'd1; exp_dat[exp_len] = 8'h00; exp_len++;
      exp_wlen = exp_len;
      exp_tmo  = (k >= el);
      for (int j = 0; j < (exp_tmo ? el : k); j++) begin
         exp_op[exp_len] = 2'd0; exp_dat[exp_len] = 8'h00; exp_len++;
         exp_op[exp_len] = 2'd2; exp_dat[exp_len] = {a, 1'b0}; exp_len++;
         exp_op[exp_len] = 2'd1; exp_dat[exp_len] = 8'h00; exp_len++;
      end
      if (!exp_tmo) begin
         exp_op[exp_len] = 2'd0; exp_dat[exp_len] = 8'h00; exp_len++;
         exp_op[exp_len] = 2'd2; exp_dat[exp_len] = {a, 1'b0}; exp_len++;
         if (!keep) begin
            exp_op[exp_len] = 2'd1; exp_dat[exp_len] = 8'h00; exp_len++;
         end
      end
   endtask

   task automatic run_txn(input logic [6:0] a, input int n, input logic [MAXB*8-1:0] p,
                          input int k, input int lim, input bit keep, input bit inject);
      bit got_done = 0, got_tmo = 0;
      int waited = 0;
      int wbad = -1, pbad = -1;
      int len_end;
      build_expect(a, n, p, k, lim, keep);
      log_len = 0; stop_cnt = 0; poll_i = 0; busy_polls = k;
      stop_done_cyc = -1; first_poll_cyc = -1; overlap_seen = 0;
      @(negedge clk);
      dev_addr = a; byte_cnt = CW'(n); payload = p;
      poll_limit = PW'(lim); keep_bus = keep; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      while (!got_done && !got_tmo && waited < 2000) begin
         @(negedge clk);
         waited++;
         if (inject && waited == 3) begin
            dev_addr = ~a; payload = ~p; go = 1'b1;   // R9 request while busy
         end else if (inject && waited == 4) begin
            go = 1'b0; dev_addr = a; payload = p;
         end
         got_done = done;
         got_tmo  = timeout;
      end
      len_end = log_len;
      check(got_done || got_tmo, "R7 completion reached", waited, 0);
      for (int i = 0; i < exp_len && i < log_len; i++) begin
         if (log_op[i] != exp_op[i] || log_dat[i] != exp_dat[i]) begin
            if (i < exp_wlen) begin if (wbad < 0) wbad = i; end
            else if (pbad < 0) pbad = i;
         end
      end
      check(wbad < 0, "R2 R10 R9 write command strobes", wbad, -1);
      check(pbad < 0, "R4 R5 poll strobes", pbad, -1);
      check(log_len == exp_len, "R5 strobe count", log_len, exp_len);
      check(got_tmo == exp_tmo, exp_tmo ? "R7 timeout outcome" : "R6 done outcome",
            int'(got_tmo), int'(exp_tmo));
      check(first_poll_cyc == stop_done_cyc + 1, "R3 immediate first probe",
            first_poll_cyc - stop_done_cyc, 1);
      check(!overlap_seen, "R8 strobe while engine busy", int'(overlap_seen), 0);
      repeat (6) @(negedge clk);
      check(log_len == len_end && !busy, "R6 R7 quiet after end", log_len - len_end, 0);
   endtask

   function automatic logic [MAXB*8-1:0] rand_payload();
      logic [MAXB*8-1:0] r;
      for (int i = 0; i < MAXB; i++) r[i*8 +: 8] = 8'($urandom);
      return r;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!busy && !done && !timeout && !cmd_valid, "R1 reset state",
            int'({busy, done, timeout, cmd_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !cmd_valid, "R1 idle after reset", int'({busy, cmd_valid}), 0);
      // directed corners
      run_txn(7'h50, 0, rand_payload(), 0, 4, 1'b1, 1'b0);   // no payload, instant ack, keep bus
      run_txn(7'h2A, 11, rand_payload(), 2, 5, 1'b0, 1'b1);  // count clamp, R9 inject
      run_txn(7'h11, 3, rand_payload(), 4, 5, 1'b0, 1'b0);   // succeed on last allowed probe
      run_txn(7'h33, 2, rand_payload(), 5, 5, 1'b1, 1'b0);   // exhaust limit
      run_txn(7'h7F, 1, rand_payload(), 1, 0, 1'b0, 1'b0);   // limit 0 acts as 1
      run_txn(7'h01, 8, rand_payload(), 0, 0, 1'b0, 1'b1);   // limit 0 with ack
      // random mix
      for (int t = 0; t < 24; t++) begin
         run_txn(7'($urandom), int'($urandom_range(0, 9)), rand_payload(),
                 int'($urandom_range(0, 6)), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule